// File: doc/BRIEF.md
# Transactional Line Buffer with Commit and Rollback Sweeps

This block is a small, fully associative buffer placed next to a processor's ordinary data cache. It holds the lines a running transaction has touched. Every line the transaction accesses is held as a pair of entries with the same address. One entry keeps the value the line had before the transaction began. The other entry takes all of the transaction's tentative writes. When the transaction ends, a single operation retags every entry in one cycle. A commit keeps the tentative copies and frees the old ones. An abort does the reverse.

The processor issues one operation at a time. There are three transactional accesses (load, load with intent to modify, store) and three control operations (commit, abort, validate). Each operation returns a pass/fail result and, for accesses, a data word. A line that is not present is read through a memory-fetch port. The fetch can answer with data or with a conflict failure. Either a conflict or a lack of free entries rolls the transaction back and clears the status flag. Until software acknowledges the failure through validate, commit or abort, later accesses are refused. A bus snoop port sees only committed lines, never the entries of a transaction in flight.

Top module: `txc_top`

## Requirements
- R1: After reset every entry is empty, `tactive` is 0, `tstatus` is 1, `op_ready` is 1, and no response or memory request is pending.
- R2: An operation is taken when `op_valid` and `op_ready` are both high. Op codes are: 0 load, 1 load-exclusive, 2 store, 3 commit, 4 abort, 5 validate. Codes 6 and 7 answer failure and change nothing. Any operation that needs no fetch raises `rsp_valid` for one cycle, in the cycle after it was taken. `rsp_data` is 0 for control operations and for failures.
- R3: An access to an address whose tentative copy exists uses that copy and issues no fetch. A load returns the tentative value. A store overwrites it and returns the stored value.
- R4: An access to an address held as a committed line issues no fetch, provided one entry is free. It turns that line into the tentative copy and places a saved copy in a free entry. A store writes its data into the tentative copy; a load returns the line's value.
- R5: An access to an absent address needs two free entries. It raises `mem_req_valid` with the address held steady until `mem_rsp_valid`. It responds in the cycle after the fetch reply. It creates the saved copy with the fetched data, and the tentative copy with the fetched data or, for a store, with the store data.
- R6: Commit with `tstatus` 1 answers success, makes every tentative value a committed line and frees every saved copy.
- R7: Abort answers success, frees every tentative copy and makes every saved copy a committed line again.
- R8: A fetch answered with failure clears `tstatus`, rolls every pair back as in R7 and answers failure.
- R9: An access that needs more free entries than exist evicts nothing. It issues no fetch, clears `tstatus`, rolls back as in R7 and answers failure.
- R10: While `tstatus` is 0, accesses answer failure, issue no fetch and leave all entries unchanged.
- R11: Validate answers the current `tstatus`. If that value is 0, validate also clears `tactive` and sets `tstatus` to 1.
- R12: Commit with `tstatus` 0 answers failure and acts as an abort.
- R13: Every accepted access sets `tactive`. Commit and abort leave `tactive` 0 and `tstatus` 1.
- R14: With `snp_valid` high, `snp_hit` is 1 only when a committed line holds `snp_addr`, and `snp_data` is then that line's value. Saved and tentative copies never hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation code (R2) |
| op_addr | input | AW | Line address of an access |
| op_wdata | input | DW | Store data |
| op_ready | output | 1 | Block can take an operation |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Operation succeeded / status read by validate |
| rsp_data | output | DW | Data returned by an access |
| mem_req_valid | output | 1 | Line fetch outstanding |
| mem_req_addr | output | AW | Address of the fetch |
| mem_rsp_valid | input | 1 | Fetch reply strobe |
| mem_rsp_fail | input | 1 | Fetch lost to a conflict |
| mem_rsp_data | input | DW | Fetched line data |
| snp_valid | input | 1 | Snoop lookup enable |
| snp_addr | input | AW | Snoop lookup address |
| snp_hit | output | 1 | Committed line found |
| snp_data | output | DW | Data of the committed line |
| tactive | output | 1 | Transaction in progress flag |
| tstatus | output | 1 | Transaction still viable flag |

## Verification
The bench keeps its own per-address model: each address is absent, committed, or paired with a saved and a tentative value. It drives random operation mixes through that model, then adds directed corner cases on top.

Filling all eight entries and then missing once more must roll back with no fetch. A design that evicted a pair there, or that asked memory anyway, would lose the saved value or show a spurious request. A conflicting fetch, followed by a refused access, two validates and a failed commit, exposes any design that forgets to clear the status flag. It also catches a design that commits tentative data after a failure. Stores that hit a committed line, followed by an abort, catch a swapped sweep: the snoop port would then report the store data instead of the old value. A snoop scan of every address after every operation catches transactional entries leaking to the bus.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [1:0] {
    ENT_EMPTY   = 2'd0,
    ENT_NORMAL  = 2'd1,
    ENT_XCOMMIT = 2'd2,
    ENT_XABORT  = 2'd3
  } ent_state_e;

  typedef enum logic [2:0] {
    OP_LOAD     = 3'd0,
    OP_LOADX    = 3'd1,
    OP_STORE    = 3'd2,
    OP_COMMIT   = 3'd3,
    OP_ABORT    = 3'd4,
    OP_VALIDATE = 3'd5
  } txn_op_e;

  typedef enum logic [1:0] {
    SWEEP_NONE     = 2'd0,
    SWEEP_COMMIT   = 2'd1,
    SWEEP_ROLLBACK = 2'd2
  } sweep_e;

  // State an entry takes when a bulk retag is applied.
  function automatic ent_state_e swept_state(ent_state_e s, sweep_e k);
    ent_state_e r;
    r = s;
    if (k == SWEEP_COMMIT) begin
      if (s == ENT_XCOMMIT) r = ENT_EMPTY;
      else if (s == ENT_XABORT) r = ENT_NORMAL;
    end else if (k == SWEEP_ROLLBACK) begin
      if (s == ENT_XABORT) r = ENT_EMPTY;
      else if (s == ENT_XCOMMIT) r = ENT_NORMAL;
    end
    return r;
  endfunction

endpackage

// File: rtl/txc_entries.sv
module txc_entries
  import txc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  sweep_e                         sweep,
  input  logic                           wa_en,
  input  logic [IW-1:0]                  wa_idx,
  input  ent_state_e                     wa_state,
  input  logic [AW-1:0]                  wa_tag,
  input  logic [DW-1:0]                  wa_data,
  input  logic                           wb_en,
  input  logic [IW-1:0]                  wb_idx,
  input  ent_state_e                     wb_state,
  input  logic [AW-1:0]                  wb_tag,
  input  logic [DW-1:0]                  wb_data,
  input  logic [IW-1:0]                  rd_idx,
  output logic [DW-1:0]                  rd_data,
  input  logic [IW-1:0]                  snp_idx,
  output logic [DW-1:0]                  snp_data,
  output ent_state_e [NUM_ENT-1:0]       st_q,
  output logic [NUM_ENT-1:0][AW-1:0]     tag_q
);

  ent_state_e [NUM_ENT-1:0]   st_d;
  logic [NUM_ENT-1:0][DW-1:0] data_q;

  // Next state: bulk retag first, then the targeted writes.
  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      st_d[i] = swept_state(st_q[i], sweep);
    end
    if (wa_en) st_d[wa_idx] = wa_state;
    if (wb_en) st_d[wb_idx] = wb_state;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) st_q[i] <= ENT_EMPTY;
    end else begin
      st_q <= st_d;
    end
  end

  logic [NUM_ENT-1:0] xc_vec;
  logic [NUM_ENT-1:0] xa_vec;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    logic sel_a;
    logic sel_b;
    assign sel_a = wa_en && (wa_idx == IW'(g));
    assign sel_b = wb_en && (wb_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (sel_a) begin
        tag_q[g]  <= wa_tag;
        data_q[g] <= wa_data;
      end else if (sel_b) begin
        tag_q[g]  <= wb_tag;
        data_q[g] <= wb_data;
      end
    end
    assign xc_vec[g] = (st_q[g] == ENT_XCOMMIT);
    assign xa_vec[g] = (st_q[g] == ENT_XABORT);
  end

  assign rd_data  = data_q[rd_idx];
  assign snp_data = data_q[snp_idx];

  // R4/R5: saved and tentative copies always exist in pairs.
  assert_pairs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(xc_vec) == $countones(xa_vec));

  // R6 and R7: after any sweep no transactional entry survives.
  assert_sweep_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep != SWEEP_NONE) |=> (xc_vec == '0 && xa_vec == '0));

endmodule

// File: rtl/txc_lookup.sv
module txc_lookup
  import txc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW = 16,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CW = $clog2(NUM_ENT + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ent_state_e [NUM_ENT-1:0]    st_vec,
  input  logic [NUM_ENT-1:0][AW-1:0]  tag_vec,
  input  logic [AW-1:0]               look_addr,
  input  logic                        snp_valid,
  input  logic [AW-1:0]               snp_addr,
  output logic                        xa_hit,
  output logic [IW-1:0]               xa_idx,
  output logic                        nm_hit,
  output logic [IW-1:0]               nm_idx,
  output logic                        snp_hit,
  output logic [IW-1:0]               snp_idx,
  output logic [CW-1:0]               free_cnt,
  output logic [IW-1:0]               free0_idx,
  output logic [IW-1:0]               free1_idx
);

  logic [NUM_ENT-1:0] xa_m;
  logic [NUM_ENT-1:0] nm_m;
  logic [NUM_ENT-1:0] sn_m;
  logic [NUM_ENT-1:0] fr_m;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign xa_m[g] = (st_vec[g] == ENT_XABORT) && (tag_vec[g] == look_addr);
    assign nm_m[g] = (st_vec[g] == ENT_NORMAL) && (tag_vec[g] == look_addr);
    assign sn_m[g] = (st_vec[g] == ENT_NORMAL) && (tag_vec[g] == snp_addr);
    assign fr_m[g] = (st_vec[g] == ENT_EMPTY);
  end

  always_comb begin
    xa_idx    = '0;
    nm_idx    = '0;
    snp_idx   = '0;
    free0_idx = '0;
    free1_idx = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (xa_m[i]) xa_idx = IW'(i);
      if (nm_m[i]) nm_idx = IW'(i);
      if (sn_m[i]) snp_idx = IW'(i);
    end
    // Descending scan leaves the lowest free index in slot 0, next in slot 1.
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (fr_m[i]) begin
        free1_idx = free0_idx;
        free0_idx = IW'(i);
      end
    end
  end

  assign xa_hit   = |xa_m;
  assign nm_hit   = |nm_m;
  assign snp_hit  = snp_valid && (|sn_m);
  assign free_cnt = CW'($countones(fr_m));

  // R14: an address is held by at most one entry of each kind.
  assert_unique_match_R14: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xa_m) && $onehot0(nm_m) && $onehot0(sn_m));

endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl
  import txc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW = 16,
  parameter int DW = 32,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CW = $clog2(NUM_ENT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic [AW-1:0]  op_addr,
  input  logic [DW-1:0]  op_wdata,
  output logic           op_ready,
  output logic           rsp_valid,
  output logic           rsp_ok,
  output logic [DW-1:0]  rsp_data,
  output logic           mem_req_valid,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic           mem_rsp_fail,
  input  logic [DW-1:0]  mem_rsp_data,
  output logic           tactive,
  output logic           tstatus,
  output logic [AW-1:0]  look_addr,
  input  logic           xa_hit,
  input  logic [IW-1:0]  xa_idx,
  input  logic           nm_hit,
  input  logic [IW-1:0]  nm_idx,
  input  logic [CW-1:0]  free_cnt,
  input  logic [IW-1:0]  free0_idx,
  input  logic [IW-1:0]  free1_idx,
  output logic [IW-1:0]  rd_idx,
  input  logic [DW-1:0]  rd_data,
  output sweep_e         sweep,
  output logic           wa_en,
  output logic [IW-1:0]  wa_idx,
  output ent_state_e     wa_state,
  output logic [AW-1:0]  wa_tag,
  output logic [DW-1:0]  wa_data,
  output logic           wb_en,
  output logic [IW-1:0]  wb_idx,
  output ent_state_e     wb_state,
  output logic [AW-1:0]  wb_tag,
  output logic [DW-1:0]  wb_data
);

  typedef enum logic {FSM_IDLE = 1'b0, FSM_FETCH = 1'b1} fsm_e;

  fsm_e          fsm_q, fsm_d;
  logic          tact_q, tact_d;
  logic          tstat_q, tstat_d;
  logic          rsp_v_q, rsp_fire;
  logic          rsp_ok_q, rsp_ok_d;
  logic [DW-1:0] rsp_data_q, rsp_data_d;
  logic          pend_ld;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_wdata_q;
  logic          pend_store_q;
  logic [IW-1:0] pend_i0_q, pend_i1_q;
  logic          take_fail;
  txn_op_e       op;
  logic          is_store;
  logic [DW-1:0] new_val;

  assign op        = txn_op_e'(op_code);
  assign is_store  = (op == OP_STORE);
  assign look_addr = (fsm_q == FSM_FETCH) ? pend_addr_q : op_addr;
  assign rd_idx    = xa_hit ? xa_idx : nm_idx;
  assign new_val   = is_store ? op_wdata : rd_data;

  always_comb begin
    fsm_d      = fsm_q;
    tact_d     = tact_q;
    tstat_d    = tstat_q;
    rsp_fire   = 1'b0;
    rsp_ok_d   = 1'b0;
    rsp_data_d = '0;
    pend_ld    = 1'b0;
    take_fail  = 1'b0;
    sweep      = SWEEP_NONE;
    wa_en      = 1'b0;
    wa_idx     = '0;
    wa_state   = ENT_EMPTY;
    wa_tag     = op_addr;
    wa_data    = '0;
    wb_en      = 1'b0;
    wb_idx     = '0;
    wb_state   = ENT_EMPTY;
    wb_tag     = op_addr;
    wb_data    = '0;

    if (fsm_q == FSM_IDLE) begin
      if (op_valid) begin
        case (op)
          OP_LOAD, OP_LOADX, OP_STORE: begin
            tact_d = 1'b1;
            if (!tstat_q) begin
              rsp_fire = 1'b1;
            end else if (xa_hit) begin
              rsp_fire   = 1'b1;
              rsp_ok_d   = 1'b1;
              rsp_data_d = new_val;
              if (is_store) begin
                wa_en    = 1'b1;
                wa_idx   = xa_idx;
                wa_state = ENT_XABORT;
                wa_data  = op_wdata;
              end
            end else if (nm_hit) begin
              if (free_cnt >= CW'(1)) begin
                rsp_fire   = 1'b1;
                rsp_ok_d   = 1'b1;
                rsp_data_d = new_val;
                wa_en      = 1'b1;
                wa_idx     = nm_idx;
                wa_state   = ENT_XABORT;
                wa_data    = new_val;
                wb_en      = 1'b1;
                wb_idx     = free0_idx;
                wb_state   = ENT_XCOMMIT;
                wb_data    = rd_data;
              end else begin
                take_fail = 1'b1;
              end
            end else if (free_cnt >= CW'(2)) begin
              fsm_d   = FSM_FETCH;
              pend_ld = 1'b1;
            end else begin
              take_fail = 1'b1;
            end
          end
          OP_COMMIT: begin
            rsp_fire = 1'b1;
            rsp_ok_d = tstat_q;
            sweep    = tstat_q ? SWEEP_COMMIT : SWEEP_ROLLBACK;
            tact_d   = 1'b0;
            tstat_d  = 1'b1;
          end
          OP_ABORT: begin
            rsp_fire = 1'b1;
            rsp_ok_d = 1'b1;
            sweep    = SWEEP_ROLLBACK;
            tact_d   = 1'b0;
            tstat_d  = 1'b1;
          end
          OP_VALIDATE: begin
            rsp_fire = 1'b1;
            rsp_ok_d = tstat_q;
            if (!tstat_q) begin
              tact_d  = 1'b0;
              tstat_d = 1'b1;
            end
          end
          default: rsp_fire = 1'b1;
        endcase
      end
    end else begin
      wa_tag = pend_addr_q;
      wb_tag = pend_addr_q;
      if (mem_rsp_valid) begin
        fsm_d = FSM_IDLE;
        if (mem_rsp_fail) begin
          take_fail = 1'b1;
        end else begin
          rsp_fire   = 1'b1;
          rsp_ok_d   = 1'b1;
          rsp_data_d = pend_store_q ? pend_wdata_q : mem_rsp_data;
          wa_en      = 1'b1;
          wa_idx     = pend_i0_q;
          wa_state   = ENT_XCOMMIT;
          wa_data    = mem_rsp_data;
          wb_en      = 1'b1;
          wb_idx     = pend_i1_q;
          wb_state   = ENT_XABORT;
          wb_data    = rsp_data_d;
        end
      end
    end

    if (take_fail) begin
      sweep      = SWEEP_ROLLBACK;
      tstat_d    = 1'b0;
      rsp_fire   = 1'b1;
      rsp_ok_d   = 1'b0;
      rsp_data_d = '0;
      wa_en      = 1'b0;
      wb_en      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= FSM_IDLE;
      tact_q     <= 1'b0;
      tstat_q    <= 1'b1;
      rsp_v_q    <= 1'b0;
      rsp_ok_q   <= 1'b0;
      rsp_data_q <= '0;
    end else begin
      fsm_q   <= fsm_d;
      tact_q  <= tact_d;
      tstat_q <= tstat_d;
      rsp_v_q <= rsp_fire;
      if (rsp_fire) begin
        rsp_ok_q   <= rsp_ok_d;
        rsp_data_q <= rsp_data_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend_ld) begin
      pend_addr_q  <= op_addr;
      pend_wdata_q <= op_wdata;
      pend_store_q <= is_store;
      pend_i0_q    <= free0_idx;
      pend_i1_q    <= free1_idx;
    end
  end

  assign op_ready      = (fsm_q == FSM_IDLE);
  assign rsp_valid     = rsp_v_q;
  assign rsp_ok        = rsp_ok_q;
  assign rsp_data      = rsp_data_q;
  assign mem_req_valid = (fsm_q == FSM_FETCH);
  assign mem_req_addr  = pend_addr_q;
  assign tactive       = tact_q;
  assign tstatus       = tstat_q;

  // R13: closing a transaction leaves the flags idle.
  assert_end_flags_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && (op_code == 3'd3 || op_code == 3'd4))
      |=> (!tactive && tstatus));

  // R5: a fetch stays posted with a stable address until answered.
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_rsp_valid) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R8: a conflicting fetch reply fails the operation and the transaction.
  assert_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_rsp_valid && mem_rsp_fail)
      |=> (!tstatus && rsp_valid && !rsp_ok));

  // R10: a doomed transaction gets refusals and no fetch.
  assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && op_code <= 3'd2 && !tstatus)
      |=> (rsp_valid && !rsp_ok && !mem_req_valid));

endmodule

// File: rtl/txc_top.sv
module txc_top
  import txc_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [2:0]     op_code,
  input  logic [AW-1:0]  op_addr,
  input  logic [DW-1:0]  op_wdata,
  output logic           op_ready,
  output logic           rsp_valid,
  output logic           rsp_ok,
  output logic [DW-1:0]  rsp_data,
  output logic           mem_req_valid,
  output logic [AW-1:0]  mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic           mem_rsp_fail,
  input  logic [DW-1:0]  mem_rsp_data,
  input  logic           snp_valid,
  input  logic [AW-1:0]  snp_addr,
  output logic           snp_hit,
  output logic [DW-1:0]  snp_data,
  output logic           tactive,
  output logic           tstatus
);

  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int CW = $clog2(NUM_ENT + 1);

  ent_state_e [NUM_ENT-1:0]    st_vec;
  logic [NUM_ENT-1:0][AW-1:0]  tag_vec;
  logic [AW-1:0]               look_addr;
  logic                        xa_hit, nm_hit;
  logic [IW-1:0]               xa_idx, nm_idx, snp_idx;
  logic [CW-1:0]               free_cnt;
  logic [IW-1:0]               free0_idx, free1_idx;
  logic [IW-1:0]               rd_idx;
  logic [DW-1:0]               rd_data;
  sweep_e                      sweep;
  logic                        wa_en, wb_en;
  logic [IW-1:0]               wa_idx, wb_idx;
  ent_state_e                  wa_state, wb_state;
  logic [AW-1:0]               wa_tag, wb_tag;
  logic [DW-1:0]               wa_data, wb_data;

  txc_entries #(.NUM_ENT(NUM_ENT), .AW(AW), .DW(DW)) u_entries (
    .clk(clk), .rst_n(rst_n), .sweep(sweep),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_state(wb_state), .wb_tag(wb_tag), .wb_data(wb_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .snp_idx(snp_idx), .snp_data(snp_data),
    .st_q(st_vec), .tag_q(tag_vec)
  );

  txc_lookup #(.NUM_ENT(NUM_ENT), .AW(AW)) u_lookup (
    .clk(clk), .rst_n(rst_n), .st_vec(st_vec), .tag_vec(tag_vec),
    .look_addr(look_addr), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .xa_hit(xa_hit), .xa_idx(xa_idx), .nm_hit(nm_hit), .nm_idx(nm_idx),
    .snp_hit(snp_hit), .snp_idx(snp_idx), .free_cnt(free_cnt),
    .free0_idx(free0_idx), .free1_idx(free1_idx)
  );

  txc_ctrl #(.NUM_ENT(NUM_ENT), .AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fail(mem_rsp_fail), .mem_rsp_data(mem_rsp_data),
    .tactive(tactive), .tstatus(tstatus), .look_addr(look_addr),
    .xa_hit(xa_hit), .xa_idx(xa_idx), .nm_hit(nm_hit), .nm_idx(nm_idx),
    .free_cnt(free_cnt), .free0_idx(free0_idx), .free1_idx(free1_idx),
    .rd_idx(rd_idx), .rd_data(rd_data), .sweep(sweep),
    .wa_en(wa_en), .wa_idx(wa_idx), .wa_state(wa_state), .wa_tag(wa_tag), .wa_data(wa_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_state(wb_state), .wb_tag(wb_tag), .wb_data(wb_data)
  );

endmodule

// File: tb/sim_txc_top.sv
`timescale 1ns/100ps
module sim_txc_top;

  localparam int NE = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int NA = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_code = '0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic op_ready, rsp_valid, rsp_ok, mem_req_valid, snp_hit, tactive, tstatus;
  logic [DW-1:0] rsp_data, snp_data;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_fail = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;

  always #2.5 clk = ~clk;

  txc_top #(.NUM_ENT(NE), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .op_ready(op_ready),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_fail(mem_rsp_fail), .mem_rsp_data(mem_rsp_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_hit(snp_hit), .snp_data(snp_data),
    .tactive(tactive), .tstatus(tstatus)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Reference model, one record per address.
  bit            m_pres [NA];
  bit            m_intx [NA];
  logic [DW-1:0] m_cval [NA];
  logic [DW-1:0] m_tval [NA];
  bit            m_tact;
  bit            m_tstat;

  function automatic logic [DW-1:0] memval(input int a);
    return 32'hA500_0000 ^ (a * 32'h0001_3579);
  endfunction

  function automatic int used_cnt();
    int n = 0;
    for (int i = 0; i < NA; i++) begin
      if (m_intx[i]) n += 2;
      else if (m_pres[i]) n += 1;
    end
    return n;
  endfunction

  task automatic chk(input bit cond, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NA; i++) begin
      m_pres[i] = 0; m_intx[i] = 0; m_cval[i] = '0; m_tval[i] = '0;
    end
    m_tact = 0; m_tstat = 1;
  endtask

  task automatic model_fail();
    m_tstat = 0;
    for (int i = 0; i < NA; i++) m_intx[i] = 0;
  endtask

  task automatic model_op(input int code, input int a, input logic [DW-1:0] wd,
                          input bit inj, output bit er, output bit eok,
                          output logic [DW-1:0] ed);
    er = 0; eok = 0; ed = '0;
    case (code)
      0, 1, 2: begin
        m_tact = 1;
        if (!m_tstat) begin
        end else if (m_intx[a]) begin
          if (code == 2) m_tval[a] = wd;
          eok = 1; ed = m_tval[a];
        end else if (m_pres[a]) begin
          if (used_cnt() < NE) begin
            m_intx[a] = 1;
            m_tval[a] = (code == 2) ? wd : m_cval[a];
            eok = 1; ed = m_tval[a];
          end else model_fail();
        end else if (used_cnt() <= NE - 2) begin
          er = 1;
          if (inj) model_fail();
          else begin
            m_pres[a] = 1; m_intx[a] = 1; m_cval[a] = memval(a);
            m_tval[a] = (code == 2) ? wd : m_cval[a];
            eok = 1; ed = m_tval[a];
          end
        end else model_fail();
      end
      3: begin
        eok = m_tstat;
        for (int i = 0; i < NA; i++) begin
          if (m_intx[i] && m_tstat) m_cval[i] = m_tval[i];
          m_intx[i] = 0;
        end
        m_tact = 0; m_tstat = 1;
      end
      4: begin
        for (int i = 0; i < NA; i++) m_intx[i] = 0;
        eok = 1; m_tact = 0; m_tstat = 1;
      end
      5: begin
        eok = m_tstat;
        if (!m_tstat) begin m_tact = 0; m_tstat = 1; end
      end
      default: ;
    endcase
  endtask

  task automatic snoop_scan();
    for (int a = 0; a < NA; a++) begin
      bit eh;
      snp_valid = 1'b1;
      snp_addr = AW'(a);
      #0.2;
      eh = m_pres[a] && !m_intx[a];
      chk(snp_hit == eh, "R14 hit", {31'b0, snp_hit}, {31'b0, eh});
      if (eh) chk(snp_data == m_cval[a], "R14 data", snp_data, m_cval[a]);
    end
    snp_valid = 1'b0;
  endtask

  task automatic run_op(input int code, input int a, input logic [DW-1:0] wd,
                        input bit inj, input string tag);
    bit er, eok, got;
    logic [DW-1:0] ed;
    int extra;
    model_op(code, a, wd, inj, er, eok, ed);
    @(negedge clk);
    chk(op_ready == 1'b1, "R2 ready", {31'b0, op_ready}, 32'd1);
    op_valid = 1'b1; op_code = 3'(code); op_addr = AW'(a); op_wdata = wd;
    @(posedge clk); #1;
    op_valid = 1'b0;
    got = mem_req_valid;
    chk(got == er, "R5 request", {31'b0, got}, {31'b0, er});
    if (got) begin
      chk(mem_req_addr == AW'(a), "R5 address", 32'(mem_req_addr), 32'(a));
      extra = int'($urandom % 3);
      for (int k = 0; k < extra; k++) begin
        @(posedge clk); #1;
        chk(mem_req_valid && !rsp_valid, "R5 hold", {31'b0, mem_req_valid}, 32'd1);
      end
      @(negedge clk);
      mem_rsp_valid = 1'b1; mem_rsp_fail = inj; mem_rsp_data = memval(a);
      @(posedge clk); #1;
      mem_rsp_valid = 1'b0; mem_rsp_fail = 1'b0;
    end
    chk(rsp_valid == 1'b1, "R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk(rsp_ok == eok, tag, {31'b0, rsp_ok}, {31'b0, eok});
    chk(rsp_data == ed, tag, rsp_data, ed);
    chk(tactive == m_tact, "R13 tactive", {31'b0, tactive}, {31'b0, m_tact});
    chk(tstatus == m_tstat, "R13 tstatus", {31'b0, tstatus}, {31'b0, m_tstat});
    snoop_scan();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0000_5EED));
    model_clear();
    do_reset();
    #1;
    // R1: idle state after reset
    chk(op_ready == 1'b1, "R1 op_ready", {31'b0, op_ready}, 32'd1);
    chk(tactive == 1'b0, "R1 tactive", {31'b0, tactive}, 32'd0);
    chk(tstatus == 1'b1, "R1 tstatus", {31'b0, tstatus}, 32'd1);
    chk(!rsp_valid && !mem_req_valid, "R1 idle", {31'b0, rsp_valid}, 32'd0);
    snoop_scan();

    // Miss, tentative store hit, commit
    run_op(0, 3, '0, 0, "R5 load miss");
    run_op(2, 3, 32'h0000_0111, 0, "R3 store hit");
    run_op(1, 3, '0, 0, "R3 loadx hit");
    run_op(3, 0, '0, 0, "R6 commit");
    // Store on a committed line, then abort restores it
    run_op(2, 3, 32'h0000_0222, 0, "R4 committed hit");
    run_op(4, 0, '0, 0, "R7 abort");
    run_op(2, 5, 32'h0000_0333, 0, "R5 store miss");
    run_op(3, 0, '0, 0, "R6 commit store");
    run_op(6, 1, '0, 0, "R2 undefined code");

    // Capacity: fill every entry, then one more miss
    do_reset();
    for (int a = 0; a < 4; a++) run_op(0, a, '0, 0, "R5 fill");
    run_op(0, 4, '0, 0, "R9 full");
    run_op(0, 5, '0, 0, "R10 refused");
    run_op(2, 0, 32'h0000_0444, 0, "R10 refused hit");
    run_op(5, 0, '0, 0, "R11 validate failed");
    run_op(5, 0, '0, 0, "R11 validate ok");
    // Conflicting fetch, then commit must fail
    run_op(0, 6, '0, 1, "R8 conflict");
    run_op(3, 0, '0, 0, "R12 commit failed");
    run_op(0, 0, '0, 0, "R4 committed hit");
    run_op(3, 0, '0, 0, "R6 commit");

    // Random traffic
    for (int r = 0; r < 6; r++) begin
      do_reset();
      for (int n = 0; n < 80; n++) begin
        int p, code, a;
        p = int'($urandom % 100);
        if (p < 70) code = p % 3;
        else if (p < 82) code = 3;
        else if (p < 90) code = 4;
        else code = 5;
        a = int'($urandom % 12);
        run_op(code, a, $urandom, ($urandom % 100) < 8, "R2 random");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule